// File: doc/BRIEF.md
# Pipeline Hazard and Exception Controller

This block is the control unit of a five-stage processor pipeline (fetch, decode, execute, memory, writeback). Each cycle it looks at the instruction codes held in the decode, execute and memory pipeline registers, the source register IDs read in decode, and the load destination ID in execute. It also takes the branch outcome computed in execute and the status codes carried in the memory and writeback stages. From these it produces hold (stall) and squash (bubble) controls for the pipeline registers. It also produces a write enable for the condition-code register.

Four situations are resolved in one place. The first is a value consumed in decode that a load in execute has not yet fetched. The second is a return instruction whose target is unknown until it retires. The third is a conditional branch that was predicted taken but was not taken. The fourth is an instruction that has faulted. A fault blocks architectural side effects from younger instructions, and once a faulting status reaches writeback the pipeline is frozen until reset.

Top module: `hzc_ctrl`

## Requirements
- R1: When the execute icode is a load (4'h5 register-from-memory move or 4'hB pop), its destination ID is not 4'hF, and that ID equals either decode source ID, f_stall, d_stall and e_bubble are all 1.
- R2: A load destination of 4'hF never causes a load-use hazard, even when a decode source is also 4'hF. A non-load execute icode never causes one either.
- R3: When the return icode 4'h9 is in decode, execute or memory, f_stall is 1 and d_bubble is 1, unless R4 applies.
- R4: When a load-use hazard (R1) and a return (R3) occur together, d_stall is 1 and d_bubble is 0.
- R5: When the execute icode is the conditional jump 4'h7 and e_cnd is 0, d_bubble and e_bubble are 1. No misprediction is flagged when e_cnd is 1.
- R6: cc_en is 1 exactly when the execute icode is the ALU operation 4'h6, both m_stat and w_stat are 0 (normal), and the pipeline is not stopped.
- R7: m_bubble is 1 whenever m_stat or w_stat is non-zero, and also while the pipeline is stopped.
- R8: A non-zero w_stat drives w_stall to 1 at once. From the next clock edge the pipeline is stopped: w_stall and m_bubble stay 1 and cc_en stays 0 until rst_n is asserted.
- R9: d_stall and d_bubble are never 1 together.
- R10: After reset, with all icodes at nop 4'h1, non-matching register IDs and normal status 0, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears the stop state |
| d_icode | input | 4 | Instruction code in decode |
| e_icode | input | 4 | Instruction code in execute |
| m_icode | input | 4 | Instruction code in memory |
| d_src_a | input | 4 | First register source read in decode (4'hF = none) |
| d_src_b | input | 4 | Second register source read in decode (4'hF = none) |
| e_dst_m | input | 4 | Load destination of the execute instruction (4'hF = none) |
| e_cnd | input | 1 | Branch condition evaluated in execute (1 = taken) |
| m_stat | input | 2 | Status in memory stage (0 normal, 1 halt, 2 bad address, 3 bad instruction) |
| w_stat | input | 2 | Status in writeback stage, same encoding |
| f_stall | output | 1 | Hold the fetch register |
| d_stall | output | 1 | Hold the decode register |
| d_bubble | output | 1 | Load a nop into the decode register |
| e_bubble | output | 1 | Load a nop into the execute register |
| m_bubble | output | 1 | Load a nop into the memory register |
| w_stall | output | 1 | Hold the writeback register (pipeline stopped) |
| cc_en | output | 1 | Condition-code write enable |

## Verification
The assertions assume that instruction codes are in the range 4'h0 to 4'hB and that e_dst_m is 4'hF for non-load instructions. The bench keeps to this: its sweeps draw icodes only from that range. It also counts on the datapath clearing the status of any bubble it inserts, which is why a squashed instruction can never show up later as a fault. The bench drives w_stat non-zero only in a dedicated stop sequence followed by reset. In every other sweep w_stat stays normal, so the sticky stop state does not mask the other checks.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
  localparam int ICODE_W = 4;
  localparam int REG_W   = 4;
  localparam int STAT_W  = 2;

  localparam logic [REG_W-1:0]  REG_NONE = '1;
  localparam logic [STAT_W-1:0] ST_OK    = '0;

  typedef enum logic [ICODE_W-1:0] {
    IC_HALT  = 4'h0,
    IC_NOP   = 4'h1,
    IC_RRMV  = 4'h2,
    IC_IRMV  = 4'h3,
    IC_RMMV  = 4'h4,
    IC_MRMV  = 4'h5,
    IC_ALU   = 4'h6,
    IC_JMP   = 4'h7,
    IC_CALL  = 4'h8,
    IC_RET   = 4'h9,
    IC_PUSH  = 4'hA,
    IC_POP   = 4'hB
  } icode_e;
endpackage

// File: rtl/hzc_load_use.sv
module hzc_load_use
  import hzc_pkg::*;
(
  input  logic [ICODE_W-1:0] e_icode,
  input  logic [REG_W-1:0]   e_dst_m,
  input  logic [REG_W-1:0]   d_src_a,
  input  logic [REG_W-1:0]   d_src_b,
  output logic               hazard
);
  logic is_load;
  logic dst_live;
  logic hit;

  always_comb begin
    is_load  = (e_icode == IC_MRMV) || (e_icode == IC_POP);
    dst_live = (e_dst_m != REG_NONE);
    hit      = (e_dst_m == d_src_a) || (e_dst_m == d_src_b);
    hazard   = is_load && dst_live && hit;
  end
endmodule

// File: rtl/hzc_flow.sv
module hzc_flow
  import hzc_pkg::*;
(
  input  logic [ICODE_W-1:0] d_icode,
  input  logic [ICODE_W-1:0] e_icode,
  input  logic [ICODE_W-1:0] m_icode,
  input  logic               e_cnd,
  output logic               ret_pending,
  output logic               mispredict
);
  localparam int NSTG = 3;
  logic [ICODE_W-1:0] stg_code [NSTG];
  logic [NSTG-1:0]    stg_ret;

  always_comb begin
    stg_code[0] = d_icode;
    stg_code[1] = e_icode;
    stg_code[2] = m_icode;
  end

  for (genvar g = 0; g < NSTG; g++) begin : g_ret
    assign stg_ret[g] = (stg_code[g] == IC_RET);
  end

  always_comb begin
    ret_pending = |stg_ret;
    mispredict  = (e_icode == IC_JMP) && !e_cnd;
  end
endmodule

// File: rtl/hzc_exc.sv
module hzc_exc
  import hzc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] m_stat,
  input  logic [STAT_W-1:0] w_stat,
  output logic              fault_any,
  output logic              stop_now
);
  logic stop_q;
  logic stop_d;
  logic stop_en;
  logic w_fault;

  always_comb begin
    w_fault   = (w_stat != ST_OK);
    stop_en   = w_fault && !stop_q;
    stop_d    = 1'b1;
    stop_now  = stop_q || w_fault;
    fault_any = stop_now || (m_stat != ST_OK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stop_q <= 1'b0;
    else if (stop_en) stop_q <= stop_d;
  end
endmodule

// File: rtl/hzc_ctrl.sv
module hzc_ctrl
  import hzc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        d_icode,
  input  logic [3:0]        e_icode,
  input  logic [3:0]        m_icode,
  input  logic [3:0]        d_src_a,
  input  logic [3:0]        d_src_b,
  input  logic [3:0]        e_dst_m,
  input  logic              e_cnd,
  input  logic [1:0]        m_stat,
  input  logic [1:0]        w_stat,
  output logic              f_stall,
  output logic              d_stall,
  output logic              d_bubble,
  output logic              e_bubble,
  output logic              m_bubble,
  output logic              w_stall,
  output logic              cc_en
);
  logic lu_haz;
  logic ret_p;
  logic mis_p;
  logic flt;
  logic stp;

  hzc_load_use u_lu (
    .e_icode (e_icode),
    .e_dst_m (e_dst_m),
    .d_src_a (d_src_a),
    .d_src_b (d_src_b),
    .hazard  (lu_haz)
  );

  hzc_flow u_flow (
    .d_icode     (d_icode),
    .e_icode     (e_icode),
    .m_icode     (m_icode),
    .e_cnd       (e_cnd),
    .ret_pending (ret_p),
    .mispredict  (mis_p)
  );

  hzc_exc u_exc (
    .clk       (clk),
    .rst_n     (rst_n),
    .m_stat    (m_stat),
    .w_stat    (w_stat),
    .fault_any (flt),
    .stop_now  (stp)
  );

  always_comb begin
    f_stall  = lu_haz || ret_p;
    d_stall  = lu_haz;
    d_bubble = mis_p || (ret_p && !lu_haz);
    e_bubble = mis_p || lu_haz;
    m_bubble = flt;
    w_stall  = stp;
    cc_en    = (e_icode == IC_ALU) && !flt;
  end
endmodule

// File: rtl/hzc_ctrl_chk.sv
module hzc_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] e_icode,
  input logic [3:0] d_src_a,
  input logic [3:0] d_src_b,
  input logic [3:0] e_dst_m,
  input logic       e_cnd,
  input logic [1:0] m_stat,
  input logic [1:0] w_stat,
  input logic       f_stall,
  input logic       d_stall,
  input logic       d_bubble,
  input logic       e_bubble,
  input logic       m_bubble,
  input logic       w_stall,
  input logic       cc_en
);
  logic ld_match;
  assign ld_match = (e_icode == 4'h5 || e_icode == 4'hB) && e_dst_m != 4'hF &&
                    (e_dst_m == d_src_a || e_dst_m == d_src_b);

  a_r1_load_use: assert property (@(posedge clk) disable iff (!rst_n)
    ld_match |-> (f_stall && d_stall && e_bubble));

  a_r2_no_dst: assert property (@(posedge clk) disable iff (!rst_n)
    (e_dst_m == 4'hF && !(e_icode == 4'h7 && !e_cnd)) |-> !e_bubble);

  a_r5_mispredict: assert property (@(posedge clk) disable iff (!rst_n)
    (e_icode == 4'h7 && !e_cnd) |-> (d_bubble && e_bubble && !d_stall));

  a_r7_fault_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    (m_stat != 2'd0 || w_stat != 2'd0) |-> (m_bubble && !cc_en));

  a_r8_stop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    w_stall |=> (w_stall && m_bubble && !cc_en));

  a_r9_d_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(d_stall && d_bubble));
endmodule

bind hzc_ctrl hzc_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .e_icode  (e_icode),
  .d_src_a  (d_src_a),
  .d_src_b  (d_src_b),
  .e_dst_m  (e_dst_m),
  .e_cnd    (e_cnd),
  .m_stat   (m_stat),
  .w_stat   (w_stat),
  .f_stall  (f_stall),
  .d_stall  (d_stall),
  .d_bubble (d_bubble),
  .e_bubble (e_bubble),
  .m_bubble (m_bubble),
  .w_stall  (w_stall),
  .cc_en    (cc_en)
);

// File: tb/sim_hzc_ctrl.sv
module sim_hzc_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] d_icode, e_icode, m_icode, d_src_a, d_src_b, e_dst_m;
  logic e_cnd;
  logic [1:0] m_stat, w_stat;
  logic f_stall, d_stall, d_bubble, e_bubble, m_bubble, w_stall, cc_en;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit stopped_m = 1'b0;

  always #2.5 clk = ~clk;

  hzc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .d_icode(d_icode), .e_icode(e_icode),
    .m_icode(m_icode), .d_src_a(d_src_a), .d_src_b(d_src_b),
    .e_dst_m(e_dst_m), .e_cnd(e_cnd), .m_stat(m_stat), .w_stat(w_stat),
    .f_stall(f_stall), .d_stall(d_stall), .d_bubble(d_bubble),
    .e_bubble(e_bubble), .m_bubble(m_bubble), .w_stall(w_stall), .cc_en(cc_en)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic chk(input string tag, input string nm, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0b expected=%0b (d=%h e=%h m=%h a=%h b=%h dst=%h c=%0b ms=%0d ws=%0d)",
               tag, nm, act, exp, d_icode, e_icode, m_icode, d_src_a, d_src_b,
               e_dst_m, e_cnd, m_stat, w_stat);
    end
  endtask

  // expected values derived from the requirement text
  task automatic check_all();
    bit lu, rt, mp, flt, stp;
    lu  = (e_icode == 4'h5 || e_icode == 4'hB) && (e_dst_m != 4'hF) &&
          (e_dst_m == d_src_a || e_dst_m == d_src_b);                 // R1, R2
    rt  = (d_icode == 4'h9) || (e_icode == 4'h9) || (m_icode == 4'h9); // R3
    mp  = (e_icode == 4'h7) && (e_cnd == 1'b0);                        // R5
    stp = stopped_m || (w_stat != 2'd0);                               // R8
    flt = stp || (m_stat != 2'd0);                                     // R7
    chk("R1,R3", "f_stall",  f_stall,  lu || rt);
    chk("R1,R4", "d_stall",  d_stall,  lu);
    chk("R3,R4,R5", "d_bubble", d_bubble, mp || (rt && !lu));
    chk("R1,R2,R5", "e_bubble", e_bubble, mp || lu);
    chk("R7", "m_bubble", m_bubble, flt);
    chk("R8", "w_stall",  w_stall,  stp);
    chk("R6", "cc_en",    cc_en,    (e_icode == 4'h6) && !flt);
    chk("R9", "d_excl",   d_stall && d_bubble, 1'b0);
  endtask

  task automatic apply(input logic [3:0] di, ei, mi, sa, sb, dm,
                       input logic c, input logic [1:0] ms, ws);
    @(negedge clk);
    d_icode = di; e_icode = ei; m_icode = mi; d_src_a = sa; d_src_b = sb;
    e_dst_m = dm; e_cnd = c; m_stat = ms; w_stat = ws;
    #1;
    check_all();
  endtask

  initial begin
    rst_n = 1'b0;
    d_icode = 4'h1; e_icode = 4'h1; m_icode = 4'h1;
    d_src_a = 4'h0; d_src_b = 4'h1; e_dst_m = 4'hF;
    e_cnd = 1'b1; m_stat = 2'd0; w_stat = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R10: idle state after reset
    chk("R10", "f_stall",  f_stall,  1'b0);
    chk("R10", "d_bubble", d_bubble, 1'b0);
    chk("R10", "m_bubble", m_bubble, 1'b0);
    chk("R10", "w_stall",  w_stall,  1'b0);
    chk("R10", "cc_en",    cc_en,    1'b0);

    // sweep of all stage icode triples, branch outcome and register match
    for (int di = 0; di < 12; di++)
      for (int ei = 0; ei < 12; ei++)
        for (int mi = 0; mi < 12; mi++)
          for (int c = 0; c < 2; c++)
            for (int mt = 0; mt < 2; mt++)
              apply(4'(di), 4'(ei), 4'(mi), 4'h0, 4'h3,
                    mt ? 4'h3 : 4'h5, 1'(c), 2'd0, 2'd0);

    // register ID sweep for load-use, including the no-register code (R2)
    for (int k = 0; k < 3; k++)
      for (int dm = 0; dm < 16; dm++)
        for (int sa = 0; sa < 16; sa++)
          for (int sb = 0; sb < 16; sb++)
            apply(4'h1, (k == 0) ? 4'h5 : (k == 1) ? 4'hB : 4'h6, 4'h1,
                  4'(sa), 4'(sb), 4'(dm), 1'b1, 2'd0, 2'd0);

    // R4 corner: load-use with a return in decode
    apply(4'h9, 4'h5, 4'h1, 4'h2, 4'hF, 4'h2, 1'b1, 2'd0, 2'd0);

    // memory-stage status sweep (R6, R7), writeback normal
    for (int ms = 0; ms < 4; ms++)
      for (int ei = 0; ei < 12; ei++)
        apply(4'h1, 4'(ei), 4'h1, 4'h0, 4'h1, 4'hF, 1'b1, 2'(ms), 2'd0);

    // R8: writeback fault stops the pipeline and stays stopped
    for (int ws = 1; ws < 4; ws++) begin
      apply(4'h1, 4'h6, 4'h1, 4'h0, 4'h1, 4'hF, 1'b1, 2'd0, 2'(ws));
      @(posedge clk);
      stopped_m = 1'b1;
      for (int r = 0; r < 4; r++)
        apply(4'h1, 4'h6, 4'h1, 4'h0, 4'h1, 4'hF, 1'b1, 2'd0, 2'd0);
      @(negedge clk) rst_n = 1'b0;
      #1;
      stopped_m = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      // R10/R8: reset clears the stop state
      apply(4'h1, 4'h6, 4'h1, 4'h0, 4'h1, 4'hF, 1'b1, 2'd0, 2'd0);
    end

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule